// File: doc/BRIEF.md
# Masked CAM Match Engine

This block is a small content-addressable lookup table. It holds 16 entries of 64 bits, each with its own valid bit, and compares a presented key against every valid entry at once. A 64-bit global mask selects which bit positions take part in the compare. A lookup reports completion and hit on separate one-cycle strobes. On a hit, the block drives the low 32 bits of the winning entry onto a result bus and raises that bus's output enable.

Keys arrive over a 32-bit bus. A latch-low strobe captures the lower key half. A start strobe captures the upper key half and launches the compare, which completes a fixed eight cycles later. Start strobes that come too soon after the previous accepted one are dropped.

An ATM mode adds a path-only fallback. In this mode, an entry whose circuit field is all ones hits on its path field alone, and a separate flag reports that kind of hit. Entries are loaded through a simple single-cycle write port.

Top module: `masked_cam_engine`

## Requirements
- R1: Mask bit value 0 makes the matching key bit take part in the compare. Mask bit value 1 makes that bit ignored. Bit n of the mask governs bit n of both the entry and the key.
- R2: On a hit, `result_o` carries bits 31:0 of the winning entry and `result_oe_o` is 1, whichever bits the mask selects for comparison.
- R3: A pulse on `latch_lo_i` loads `key_i` into key bits 31:0. An accepted `start_i` loads `key_i` into key bits 63:32 and begins a compare. If no new latch-low pulse arrives before a start, key bits 31:0 keep their last latched value, which is 0 after reset.
- R4: `match_done_o` is a one-cycle pulse. It is visible in the cycle after the 8th rising edge that follows the edge sampling an accepted start, for every compare, hit or miss.
- R5: `match_hit_o` pulses together with `match_done_o` only when at least one valid entry hits.
- R6: On a miss, `result_oe_o` stays 0 and `result_o` reads 0, so several tables may share the bus.
- R7: A start sampled fewer than 10 edges after the previous accepted start is ignored. A start exactly 10 edges later is accepted.
- R8: With `atm_mode_i`=1, an entry hits as a path entry when its bits 47:32 are all ones and its bits 59:48 equal key bits 59:48 on the unmasked positions. This raises `path_hit_o` together with `match_hit_o`. With `atm_mode_i`=0 no path-only hit occurs.
- R9: An exact hit on any entry wins over a path-only hit, and `path_hit_o` is then 0. Among several hits of the winning kind, the lowest entry index supplies the result.
- R10: A write with `wr_valid_i`=1 stores `wr_data_i` at `wr_idx_i` and makes it valid. A write with `wr_valid_i`=0 invalidates that slot. Invalid entries never hit, and reset invalidates every entry.
- R11: Result data and output enable hold from the completion of a hit until the next accepted start, which clears both.
- R12: After reset, all strobes, `result_oe_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 4 | Entry slot to write |
| wr_data_i | input | 64 | Entry contents |
| wr_valid_i | input | 1 | Valid bit stored with the write |
| mask_i | input | 64 | Global mask, 1 = ignore bit |
| atm_mode_i | input | 1 | Enables path-only fallback matching |
| key_i | input | 32 | Key half bus |
| latch_lo_i | input | 1 | Capture key_i as key bits 31:0 |
| start_i | input | 1 | Capture key_i as key bits 63:32 and start compare |
| match_done_o | output | 1 | Compare complete pulse |
| match_hit_o | output | 1 | Hit pulse |
| path_hit_o | output | 1 | Path-only hit pulse (ATM mode) |
| result_o | output | 32 | Low 32 bits of the winning entry |
| result_oe_o | output | 1 | Result bus drive enable |

## Verification
The table and the lower key half are sampled on the edge that completes a compare, not on the start edge. The assertions and the scoreboard therefore assume that no entry write, mask change or latch-low pulse lands inside the eight-cycle compare window. The stimulus loads entries, the mask and the lower key half only before a start. It then waits out the full window before touching them again. Start strobes come only from the bench's lookup task, which keeps them at least 10 edges apart except in the two scenarios that deliberately probe the spacing rule at 9 and at 10 edges.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_ENTRY_W = 64;
  localparam int unsigned DEF_HALF_W  = 32;
  localparam int unsigned DEF_LAT     = 8;
  localparam int unsigned DEF_GAP     = 10;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_EXACT = 2'd1,
    WIN_PATH  = 2'd2
  } win_kind_e;
endpackage

// File: rtl/cam_key_capture.sv
module cam_key_capture #(
  parameter int HALF_W = 32,
  parameter int LAT    = 8,
  parameter int GAP    = 10,
  localparam int GW    = $clog2(GAP + 1),
  localparam int LW    = $clog2(LAT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HALF_W-1:0]   key_i,
  input  logic                latch_lo_i,
  input  logic                start_i,
  output logic [2*HALF_W-1:0] key_o,
  output logic                accept_o,
  output logic                finish_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [GW-1:0]     gap_q;
  logic [LW-1:0]     lat_q;
  logic              ready;

  assign ready    = (gap_q == '0) || (gap_q == GW'(GAP));
  assign accept_o = start_i && ready;
  assign finish_o = (lat_q == LW'(LAT));
  assign key_o    = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (latch_lo_i) lo_q <= key_i;
      if (accept_o)   hi_q <= key_i;
    end
  end

  // spacing timer: counts edges since last accepted start, saturates at GAP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 gap_q <= '0;
    else if (accept_o)                           gap_q <= GW'(1);
    else if (gap_q != '0 && gap_q != GW'(GAP))   gap_q <= gap_q + GW'(1);
  end

  // latency timer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= '0;
    else if (accept_o)          lat_q <= LW'(1);
    else if (finish_o)          lat_q <= '0;
    else if (lat_q != '0)       lat_q <= lat_q + LW'(1);
  end

  // R7
  accept_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);

  // R4
  finish_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !finish_o);
endmodule

// File: rtl/cam_entry_cmp.sv
module cam_entry_cmp #(
  parameter int ENTRY_W = 64,
  parameter int CIRC_LO = 32,
  parameter int CIRC_W  = 16,
  parameter int PATH_LO = 48,
  parameter int PATH_W  = 12
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               valid_i,
  input  logic [ENTRY_W-1:0] key_i,
  input  logic [ENTRY_W-1:0] mask_i,
  input  logic               atm_i,
  output logic               exact_o,
  output logic               path_o
);
  logic [ENTRY_W-1:0] diff;
  logic               circ_ones;

  assign diff      = (entry_i ^ key_i) & ~mask_i;
  assign circ_ones = &entry_i[CIRC_LO +: CIRC_W];
  assign exact_o   = valid_i && (diff == '0);
  assign path_o    = valid_i && atm_i && circ_ones && (diff[PATH_LO +: PATH_W] == '0);
endmodule

// File: rtl/cam_prio_pick.sv
module cam_prio_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/masked_cam_engine.sv
module masked_cam_engine
  import cam_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int ENTRY_W = DEF_ENTRY_W,
  parameter int HALF_W  = DEF_HALF_W,
  parameter int LAT     = DEF_LAT,
  parameter int GAP     = DEF_GAP,
  parameter int CIRC_LO = 32,
  parameter int CIRC_W  = 16,
  parameter int PATH_LO = 48,
  parameter int PATH_W  = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               wr_valid_i,
  input  logic [ENTRY_W-1:0] mask_i,
  input  logic               atm_mode_i,
  input  logic [HALF_W-1:0]  key_i,
  input  logic               latch_lo_i,
  input  logic               start_i,
  output logic               match_done_o,
  output logic               match_hit_o,
  output logic               path_hit_o,
  output logic [HALF_W-1:0]  result_o,
  output logic               result_oe_o
);
  logic [ENTRY_W-1:0] ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRY_W-1:0] key;
  logic               accept, finish;
  logic [ENTRIES-1:0] exact_v, path_v;
  logic               any_exact, any_path;
  logic [IDX_W-1:0]   exact_idx, path_idx, win_idx;
  win_kind_e          win;

  // entry storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (wr_en_i) begin
      ent_q[wr_idx_i] <= wr_data_i;
      vld_q[wr_idx_i] <= wr_valid_i;
    end
  end

  cam_key_capture #(.HALF_W(HALF_W), .LAT(LAT), .GAP(GAP)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_i      (key_i),
    .latch_lo_i (latch_lo_i),
    .start_i    (start_i),
    .key_o      (key),
    .accept_o   (accept),
    .finish_o   (finish)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    cam_entry_cmp #(
      .ENTRY_W(ENTRY_W), .CIRC_LO(CIRC_LO), .CIRC_W(CIRC_W),
      .PATH_LO(PATH_LO), .PATH_W(PATH_W)
    ) u_cmp (
      .entry_i (ent_q[g]),
      .valid_i (vld_q[g]),
      .key_i   (key),
      .mask_i  (mask_i),
      .atm_i   (atm_mode_i),
      .exact_o (exact_v[g]),
      .path_o  (path_v[g])
    );
  end

  cam_prio_pick #(.N(ENTRIES)) u_pick_exact (
    .req_i (exact_v), .any_o (any_exact), .idx_o (exact_idx)
  );
  cam_prio_pick #(.N(ENTRIES)) u_pick_path (
    .req_i (path_v), .any_o (any_path), .idx_o (path_idx)
  );

  always_comb begin
    if (any_exact) begin
      win     = WIN_EXACT;
      win_idx = exact_idx;
    end else if (any_path) begin
      win     = WIN_PATH;
      win_idx = path_idx;
    end else begin
      win     = WIN_NONE;
      win_idx = '0;
    end
  end

  // strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_done_o <= 1'b0;
      match_hit_o  <= 1'b0;
      path_hit_o   <= 1'b0;
    end else begin
      match_done_o <= finish;
      match_hit_o  <= finish && (win != WIN_NONE);
      path_hit_o   <= finish && (win == WIN_PATH);
    end
  end

  // result bus: released by an accepted start, driven on a hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      result_oe_o <= 1'b0;
    end else if (accept) begin
      result_o    <= '0;
      result_oe_o <= 1'b0;
    end else if (finish && win != WIN_NONE) begin
      result_o    <= ent_q[win_idx][HALF_W-1:0];
      result_oe_o <= 1'b1;
    end
  end

  // R5
  hit_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_hit_o |-> match_done_o);

  // R8
  path_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_hit_o |-> match_hit_o);

  // R6
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_oe_o |-> (result_o == '0));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_oe_o && $past(result_oe_o)) |-> $stable(result_o));

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_done_o |=> !match_done_o);
endmodule

// File: tb/tb_masked_cam_engine.sv
module tb_masked_cam_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [63:0] mask_i = '1;
  logic        atm_mode_i = 1'b0;
  logic [31:0] key_i = '0;
  logic        latch_lo_i = 1'b0;
  logic        start_i = 1'b0;
  logic        match_done_o, match_hit_o, path_hit_o, result_oe_o;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;

  logic        dv [0:20];
  logic        hv [0:20];
  logic        pv [0:20];
  logic        ov [0:20];
  logic [31:0] rv [0:20];

  masked_cam_engine dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .wr_valid_i,
    .mask_i, .atm_mode_i, .key_i, .latch_lo_i, .start_i,
    .match_done_o, .match_hit_o, .path_hit_o, .result_o, .result_oe_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d, input logic v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = d; wr_valid_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic latch_lo(input logic [31:0] lo);
    @(negedge clk_i);
    key_i = lo; latch_lo_i = 1'b1;
    @(negedge clk_i);
    latch_lo_i = 1'b0;
  endtask

  // start hi1 at edge k=0; optional second start hi2 sampled at edge k=s2 (s2=0: none)
  task automatic run(input logic [31:0] hi1, input int s2, input logic [31:0] hi2);
    @(negedge clk_i);
    key_i = hi1; start_i = 1'b1;
    for (int k = 0; k <= 20; k++) begin
      @(posedge clk_i);
      #1;
      start_i = 1'b0;
      dv[k] = match_done_o; hv[k] = match_hit_o; pv[k] = path_hit_o;
      ov[k] = result_oe_o;  rv[k] = result_o;
      if (s2 > 0 && k == s2 - 1) begin
        key_i = hi2; start_i = 1'b1;
      end
    end
  endtask

  task automatic expect_lookup(input string tag, input logic eh, input logic ep, input logic [31:0] er);
    int n = 0;
    for (int k = 1; k <= 20; k++) if (dv[k]) n++;
    chk({tag, " R4 done count"}, 64'(n), 64'd1);
    chk({tag, " R4 done at cycle 8"}, 64'(dv[8]), 64'd1);
    chk({tag, " R5 hit"}, 64'(hv[8]), 64'(eh));
    chk({tag, " R8 path"}, 64'(pv[8]), 64'(ep));
    chk({tag, " R6 oe"}, 64'(ov[9]), 64'(eh));
    chk({tag, " R2 result"}, 64'(rv[9]), 64'(eh ? er : 32'h0));
  endtask

  task automatic t_reset();
    chk("R12 done", 64'(match_done_o), 0);
    chk("R12 hit", 64'(match_hit_o), 0);
    chk("R12 path", 64'(path_hit_o), 0);
    chk("R12 oe", 64'(result_oe_o), 0);
    chk("R12 result", 64'(result_o), 0);
    mask_i = '1;
    run(32'h0, 0, 32'h0);
    expect_lookup("R10 reset invalid", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_basic();
    mask_i = 64'h0000_0000_FFFF_FFFF;
    wr(3, {32'hA5A5_0001, 32'h1111_2222}, 1'b1);
    run(32'hA5A5_0001, 0, 32'h0);
    expect_lookup("R2 basic hit", 1'b1, 1'b0, 32'h1111_2222);
    chk("R11 held", 64'(rv[20]), 64'h1111_2222);
    run(32'hA5A5_0002, 0, 32'h0);
    expect_lookup("R6 basic miss", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_mask();
    mask_i = 64'h0000_00FF_FFFF_FFFF;
    run(32'hA5A5_00FF, 0, 32'h0);
    expect_lookup("R1 ignored bits", 1'b1, 1'b0, 32'h1111_2222);
    run(32'hA5A4_0001, 0, 32'h0);
    expect_lookup("R1 compared bit", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_two_beat();
    mask_i = 64'h0;
    wr(7, {32'hCAFE_0007, 32'h0BAD_F00D}, 1'b1);
    latch_lo(32'h0BAD_F00D);
    run(32'hCAFE_0007, 0, 32'h0);
    expect_lookup("R3 two-beat hit", 1'b1, 1'b0, 32'h0BAD_F00D);
    latch_lo(32'h0BAD_F00C);
    run(32'hCAFE_0007, 0, 32'h0);
    expect_lookup("R3 low half differs", 1'b0, 1'b0, 32'h0);
    run(32'hCAFE_0007, 0, 32'h0);
    expect_lookup("R3 low half retained", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_valid();
    mask_i = 64'h0000_0000_FFFF_FFFF;
    wr(3, {32'hA5A5_0001, 32'h1111_2222}, 1'b0);
    run(32'hA5A5_0001, 0, 32'h0);
    expect_lookup("R10 invalidated", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_priority();
    mask_i = 64'h0000_0000_FFFF_FFFF;
    wr(9, {32'h1234_5678, 32'h0000_0099}, 1'b1);
    wr(2, {32'h1234_5678, 32'h0000_0022}, 1'b1);
    run(32'h1234_5678, 0, 32'h0);
    expect_lookup("R9 lowest index", 1'b1, 1'b0, 32'h0000_0022);
  endtask

  task automatic t_atm();
    mask_i = 64'hF000_0000_FFFF_FFFF;
    atm_mode_i = 1'b1;
    wr(4, {4'h0, 12'h0AB, 16'hFFFF, 32'h4444_0000}, 1'b1);
    run({4'h0, 12'h0AB, 16'h1234}, 0, 32'h0);
    expect_lookup("R8 path hit", 1'b1, 1'b1, 32'h4444_0000);
    wr(6, {4'h0, 12'h0AB, 16'h1234, 32'h0000_6666}, 1'b1);
    run({4'h0, 12'h0AB, 16'h1234}, 0, 32'h0);
    expect_lookup("R9 exact over path", 1'b1, 1'b0, 32'h0000_6666);
    run({4'h0, 12'h0AB, 16'h5555}, 0, 32'h0);
    expect_lookup("R8 path other circuit", 1'b1, 1'b1, 32'h4444_0000);
    run({4'h0, 12'h0AC, 16'h5555}, 0, 32'h0);
    expect_lookup("R8 path mismatch", 1'b0, 1'b0, 32'h0);
    atm_mode_i = 1'b0;
    run({4'h0, 12'h0AB, 16'h5555}, 0, 32'h0);
    expect_lookup("R8 no path outside ATM", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_gap();
    mask_i = 64'h0000_0000_FFFF_FFFF;
    latch_lo(32'h0);
    // second start at edge 9: ignored
    run(32'hCAFE_0007, 9, 32'h1234_5678);
    expect_lookup("R7 early start ignored", 1'b1, 1'b0, 32'h0BAD_F00D);
    chk("R7 early start result kept", 64'(rv[20]), 64'h0BAD_F00D);
    chk("R7 early start no second done", 64'(dv[17] | dv[18] | dv[19]), 0);
    // second start at edge 10: accepted
    run(32'hCAFE_0007, 10, 32'h1234_5678);
    chk("R7 first done", 64'(dv[8]), 1);
    chk("R11 oe before restart", 64'(ov[9]), 1);
    chk("R11 oe cleared by start", 64'(ov[10]), 0);
    chk("R11 result cleared by start", 64'(rv[10]), 0);
    chk("R7 second done at 18", 64'(dv[18]), 1);
    chk("R7 second hit", 64'(hv[18]), 1);
    chk("R7 second result", 64'(rv[19]), 64'h0000_0022);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_mask();
    t_two_beat();
    t_valid();
    t_priority();
    t_atm();
    t_gap();
    repeat (4) @(posedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule